// File: doc/BRIEF.md
# Dual-Edge Eight-Channel PWM Generator

This block drives eight PWM outputs from one shared 15-bit up-counter. Each channel has two 15-bit match points. The fall point forces the output low when the counter reaches it. The rise point forces it high. Both edges can therefore be placed anywhere in the period. When both points hold the same value, the output goes low.

A further 15-bit match point produces a one-clock conversion-start strobe for an external ADC. The strobe is issued only while the trigger-enable and ADC-power inputs are both high.

Every 15-bit value is written as two bytes: an upper part of 7 bits and a lower part of 8 bits. The writes go into shadow copies. The shadow copies are moved into the working set only at a period boundary, or at any time while the counter is stopped. A value that has been half written therefore never reaches the comparators.

Top module: `pwm_dual_edge_top`

## Requirements
- R1: While `runEn` is high, the counter advances by one each clock from 0 up to the active period value. On the clock after it reaches that value, it returns to 0. A period of 0 keeps it at 0.
- R2: If the counter equals a channel's active fall value while running, that channel's output is low on the following clock.
- R3: If the counter equals a channel's active rise value (and not its fall value) while running, that channel's output is high on the following clock.
- R4: If a channel's fall and rise values are equal and the counter reaches them, the output goes low.
- R5: In a running clock with no match for a channel, that channel's output keeps its level.
- R6: `adcStart` is high for exactly the clock after the running counter equals the active trigger value. It is low otherwise.
- R7: `adcStart` can only be asserted when both `trigEn` and `adcPwr` were high on the clock of the match.
- R8: Byte writes update shadow registers only. The active values take the shadow contents on the clock where the counter wraps (counter equals period), or on any clock with `runEn` low.
- R9: While `runEn` is low, the counter is held at 0, no match is acted on, and the outputs keep their levels.
- R10: During and right after reset, `pwmOut` is all zero, `adcStart` is 0, the counter is 0 and all registers are 0.
- R11: The `wrSel` values map to registers as follows:
  - 0 to 7 select the fall value of channels 0 to 7.
  - 8 to 15 select the rise value of channels 0 to 7.
  - 16 selects the period.
  - 17 selects the trigger.
  - Other values are ignored.
- R12: A write with `wrHiByte` high loads `wrData[6:0]` into bits 14:8 of the register, and `wrData[7]` is discarded. A write with `wrHiByte` low loads `wrData` into bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| runEn | input | 1 | Counter run enable |
| wrEn | input | 1 | Byte write strobe |
| wrSel | input | 5 | Register select (R11) |
| wrHiByte | input | 1 | 1 = upper 7 bits, 0 = lower 8 bits |
| wrData | input | 8 | Write byte |
| trigEn | input | 1 | ADC trigger enable |
| adcPwr | input | 1 | ADC powered indication |
| pwmOut | output | 8 | Channel outputs |
| adcStart | output | 1 | One-clock ADC conversion start |

## Verification
The assertions check the following on every clock:
- the counter bound and the hold at zero while stopped;
- the fall-wins tie rule and the rise action for each channel;
- the gating of the ADC strobe;
- that the output levels and the active period do not change outside a load or a compare.

Other behaviour needs the bench scenarios and their cycle-by-cycle reference model:
- that writes reach the active set only on a wrap;
- the byte assembly and the ignored selects;
- the exact placement of the edges and of the strobe across several periods.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int NumCh     = 8;
  localparam int CntW      = 15;
  localparam int LoW       = 8;
  localparam int HiW       = CntW - LoW;
  localparam int NumRegs   = 2 * NumCh + 2;
  localparam int SelW      = $clog2(NumRegs);
  localparam int RiseBase  = NumCh;
  localparam int PeriodIdx = 2 * NumCh;
  localparam int TrigIdx   = 2 * NumCh + 1;

  typedef struct packed {
    logic               load;   // copy shadow -> active this clock
    logic               cmpEn;  // compares act this clock
    logic [NumRegs-1:0] wrHi;   // upper-byte write strobes
    logic [NumRegs-1:0] wrLo;   // lower-byte write strobes
  } strobe_t;
endpackage

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            runEn,
  input  logic            wrEn,
  input  logic [SelW-1:0] wrSel,
  input  logic            wrHiByte,
  input  logic [CntW-1:0] periodAct,
  output logic [CntW-1:0] cnt,
  output strobe_t         strb
);
  logic atEnd;
  logic selValid;
  logic [NumRegs-1:0] selOneHot;

  assign atEnd     = (cnt >= periodAct);
  assign selValid  = (wrSel < SelW'(NumRegs));
  assign selOneHot = selValid ? (NumRegs'(1) << wrSel) : '0;

  always_comb begin
    strb.load  = !runEn || atEnd;
    strb.cmpEn = runEn;
    strb.wrHi  = (wrEn && wrHiByte)  ? selOneHot : '0;
    strb.wrLo  = (wrEn && !wrHiByte) ? selOneHot : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)       cnt <= '0;
    else if (!runEn) cnt <= '0;
    else if (atEnd)  cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R1: counter never exceeds the active period
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= periodAct);
  // R9: stopped counter is held at zero
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> cnt == '0);
  // R11: at most one register strobed per clock
  a_r11_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrHi, strb.wrLo}));
endmodule

// File: rtl/pwm_datapath.sv
module pwm_datapath
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [LoW-1:0]   wrData,
  input  logic [CntW-1:0]  cnt,
  input  logic             trigEn,
  input  logic             adcPwr,
  output logic [CntW-1:0]  periodAct,
  output logic [NumCh-1:0] pwmOut,
  output logic             adcStart
);
  logic [CntW-1:0] shadowReg [NumRegs];
  logic [CntW-1:0] activeReg [NumRegs];

  genvar r;
  generate
    for (r = 0; r < NumRegs; r++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN) begin
          shadowReg[r] <= '0;
          activeReg[r] <= '0;
        end else begin
          if (strb.wrHi[r]) shadowReg[r][CntW-1:LoW] <= wrData[HiW-1:0];
          if (strb.wrLo[r]) shadowReg[r][LoW-1:0]    <= wrData;
          if (strb.load)    activeReg[r]             <= shadowReg[r];
        end
      end
    end
  endgenerate

  assign periodAct = activeReg[PeriodIdx];

  genvar c;
  generate
    for (c = 0; c < NumCh; c++) begin : g_ch
      logic fallHit;
      logic riseHit;
      assign fallHit = (cnt == activeReg[c]);
      assign riseHit = (cnt == activeReg[RiseBase + c]);

      always_ff @(posedge clk) begin
        if (!rstN)                        pwmOut[c] <= 1'b0;
        else if (strb.cmpEn && fallHit)   pwmOut[c] <= 1'b0;
        else if (strb.cmpEn && riseHit)   pwmOut[c] <= 1'b1;
      end

      // R2/R4: fall match (including tie) gives low next clock
      a_r4_fall_wins: assert property (@(posedge clk) disable iff (!rstN)
        (strb.cmpEn && cnt == activeReg[c]) |=> !pwmOut[c]);
      // R3: lone rise match gives high next clock
      a_r3_rise: assert property (@(posedge clk) disable iff (!rstN)
        (strb.cmpEn && cnt == activeReg[RiseBase + c] && cnt != activeReg[c])
        |=> pwmOut[c]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) adcStart <= 1'b0;
    else       adcStart <= strb.cmpEn && trigEn && adcPwr &&
                           (cnt == activeReg[TrigIdx]);
  end

  // R7: strobe only when both gates were set
  a_r7_adc_gate: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> $past(trigEn && adcPwr));
  // R9: outputs frozen while compares are off
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cmpEn |=> $stable(pwmOut));
  // R8: active period only moves on a load
  a_r8_buffered: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(periodAct));
endmodule

// File: rtl/pwm_dual_edge_top.sv
module pwm_dual_edge_top
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             wrEn,
  input  logic [SelW-1:0]  wrSel,
  input  logic             wrHiByte,
  input  logic [LoW-1:0]   wrData,
  input  logic             trigEn,
  input  logic             adcPwr,
  output logic [NumCh-1:0] pwmOut,
  output logic             adcStart
);
  strobe_t         strb;
  logic [CntW-1:0] cnt;
  logic [CntW-1:0] periodAct;

  pwm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrHiByte(wrHiByte), .periodAct(periodAct), .cnt(cnt), .strb(strb)
  );

  pwm_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .cnt(cnt),
    .trigEn(trigEn), .adcPwr(adcPwr), .periodAct(periodAct),
    .pwmOut(pwmOut), .adcStart(adcStart)
  );
endmodule

// File: tb/sim_pwm_dual_edge_top.sv
module sim_pwm_dual_edge_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       runEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [4:0] wrSel = '0;
  logic       wrHiByte = 1'b0;
  logic [7:0] wrData = '0;
  logic       trigEn = 1'b0;
  logic       adcPwr = 1'b0;
  logic [7:0] pwmOut;
  logic       adcStart;

  int checks = 0;
  int fails = 0;
  string curReq = "R10";
  bit cycleCheckOn = 1'b0;
  bit finished = 1'b0;

  // reference model state
  int shd [18];
  int act [18];
  int mCnt;
  bit [7:0] mOut;
  bit mAdc;

  pwm_dual_edge_top u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrHiByte(wrHiByte), .wrData(wrData), .trigEn(trigEn), .adcPwr(adcPwr),
    .pwmOut(pwmOut), .adcStart(adcStart)
  );

  always #2 clk = ~clk;

  // behavioural model, one step per rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 18; i++) begin shd[i] = 0; act[i] = 0; end
      mCnt = 0; mOut = '0; mAdc = 1'b0;
    end else begin
      bit [7:0] nOut;
      bit nAdc;
      bit doLoad;
      int nCnt;
      nOut = mOut;
      nAdc = 1'b0;
      if (runEn) begin
        for (int ch = 0; ch < 8; ch++) begin
          if (mCnt == act[ch])         nOut[ch] = 1'b0;
          else if (mCnt == act[8+ch])  nOut[ch] = 1'b1;
        end
        nAdc = trigEn && adcPwr && (mCnt == act[17]);
      end
      doLoad = !runEn || (mCnt >= act[16]);
      nCnt = (!runEn || mCnt >= act[16]) ? 0 : mCnt + 1;
      if (doLoad)
        for (int i = 0; i < 18; i++) act[i] = shd[i];
      if (wrEn && wrSel < 18) begin
        if (wrHiByte) shd[wrSel] = (shd[wrSel] & 'hFF) | ((int'(wrData) & 'h7F) << 8);
        else          shd[wrSel] = (shd[wrSel] & 'h7F00) | int'(wrData);
      end
      mOut = nOut; mAdc = nAdc; mCnt = nCnt;
    end
  end

  task automatic check(bit ok, string req, string what, int actual, int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && cycleCheckOn && !finished) begin
      check(pwmOut == mOut, curReq, "pwmOut", pwmOut, mOut);
      check(adcStart == mAdc, curReq, "adcStart", adcStart, mAdc);
    end
  end

  task automatic wr(int sel, bit hi, int d);
    wrEn = 1'b1; wrSel = 5'(sel); wrHiByte = hi; wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wr15(int sel, int v);
    wr(sel, 1'b0, v & 'hFF);
    wr(sel, 1'b1, (v >> 8) & 'h7F);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int pulses;
    int mPulses;
    bit [7:0] saved;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(pwmOut == 8'h00, "R10", "pwmOut in reset", pwmOut, 0);
    check(adcStart == 1'b0, "R10", "adcStart in reset", adcStart, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(pwmOut == 8'h00, "R10", "pwmOut after reset", pwmOut, 0);
    cycleCheckOn = 1'b1;

    // R1 R2 R3 R5: staggered edges, period 9
    curReq = "R1 R2 R3 R5";
    wr15(16, 9);
    for (int ch = 0; ch < 8; ch++) begin
      wr15(ch, ch + 5);
      wr15(8 + ch, ch);
    end
    @(negedge clk);
    runEn = 1'b1;
    repeat (40) @(negedge clk);

    // R4: tie gives low
    curReq = "R4";
    runEn = 1'b0;
    wr15(0, 3); wr15(8, 3);
    wr15(1, 0); wr15(9, 0);
    wr15(2, 7); wr15(10, 2);
    @(negedge clk);
    runEn = 1'b1;
    repeat (30) @(negedge clk);
    check(pwmOut[0] == 1'b0, "R4", "tie ch0 level", pwmOut[0], 0);

    // R6: trigger pulses
    curReq = "R6";
    runEn = 1'b0;
    wr15(17, 4);
    trigEn = 1'b1; adcPwr = 1'b1;
    @(negedge clk);
    runEn = 1'b1;
    pulses = 0; mPulses = 0;
    repeat (30) begin
      @(negedge clk);
      if (adcStart) pulses++;
      if (mAdc) mPulses++;
    end
    check(pulses == mPulses && pulses >= 2, "R6", "pulse count", pulses, mPulses);

    // R7: gating
    curReq = "R7";
    adcPwr = 1'b0;
    pulses = 0;
    repeat (25) begin @(negedge clk); if (adcStart) pulses++; end
    check(pulses == 0, "R7", "pulses with power off", pulses, 0);
    adcPwr = 1'b1; trigEn = 1'b0;
    pulses = 0;
    repeat (25) begin @(negedge clk); if (adcStart) pulses++; end
    check(pulses == 0, "R7", "pulses with enable off", pulses, 0);
    trigEn = 1'b1;

    // R8: mid-period writes, partial writes, period change
    curReq = "R8";
    wr(2, 1'b0, 1);
    repeat (7) @(negedge clk);
    wr(10, 1'b0, 6);
    repeat (13) @(negedge clk);
    wr15(16, 20);
    wr15(11, 15);
    repeat (60) @(negedge clk);
    wr(16, 1'b1, 0);
    wr(16, 1'b0, 5);
    repeat (40) @(negedge clk);

    // R9: stopped outputs hold
    curReq = "R9";
    saved = pwmOut;
    runEn = 1'b0;
    repeat (10) begin
      @(negedge clk);
      check(pwmOut == saved, "R9", "held level", pwmOut, saved);
      check(adcStart == 1'b0, "R9", "no strobe while stopped", adcStart, 0);
    end
    runEn = 1'b1;
    repeat (20) @(negedge clk);

    // R11 R12: ignored selects, high bit of upper byte dropped
    curReq = "R11 R12";
    for (int s = 18; s < 32; s++) wr(s, s & 1, 'hA5);
    wr(3, 1'b1, 'h80);
    wr(3, 1'b0, 2);
    wr(12, 1'b1, 'h80);
    wr(12, 1'b0, 4);
    repeat (30) @(negedge clk);
    runEn = 1'b0;
    wr(16, 1'b1, 1);
    wr(16, 1'b0, 0);
    wr(4, 1'b1, 1);
    wr(4, 1'b0, 2);
    @(negedge clk);
    runEn = 1'b1;
    repeat (300) @(negedge clk);

    finish_run();
  end
endmodule